// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Channel

This block generates one pair of complementary pulse-width-modulated pin signals, a high-side and a low-side output, from a symmetric up/down timebase. The counter climbs from zero to one below the programmed half-period, then descends back to zero, so a full switching period lasts twice the half-period in clock cycles. Both pulses are centred in the period. The high-side pulse widens around the counter peak and the low-side pulse widens around the counter trough. The duty input is an offset from 50%. It lengthens the high-side pulse and shortens the low-side pulse by the same amount. The dead-time input shortens both pulses, which opens a guard gap at each transition.

The half-period, duty offset, dead time and a crossover select are plain input ports. The block copies them into shadow storage only at a period boundary, so a change made in the middle of a period first takes effect in the next period. A one-cycle sync pulse marks the first cycle of every period, and software or a sequencer can use it to pace updates such as waveform samples. When crossover is selected, the two internal waveforms trade pins, which lets the high-side pin reach duties below 50%.

Top module: `cpwm_channel`

## Requirements
- R1: While enabled, `sync_o` is high for exactly one cycle at the start of each period. Consecutive sync pulses are 2·Pe cycles apart, where Pe is the shadowed half-period.
- R2: With crossover off, `hi_o` is high for clamp(Pe + 2·(duty − dead), 0, 2·Pe) cycles in each period.
- R3: With crossover off, `lo_o` is high for clamp(Pe − 2·(duty + dead), 0, 2·Pe) cycles in each period.
- R4: Duty 0 with dead time 0 gives Pe cycles on each pin (50%). Duty Pe/2 with dead time 0 and Pe even gives 2·Pe cycles on `hi_o` and 0 cycles on `lo_o`.
- R5: `hi_o` and `lo_o` are never high in the same cycle.
- R6: With crossover set to 1, `hi_o` carries the on-time of R3 and `lo_o` carries the on-time of R2.
- R7: The half-period, duty, dead time and crossover are sampled only at the clock edge that starts a period. A change to them inside a period leaves that period's length and on-times unchanged.
- R8: While `en_i` is low, both pins and `sync_o` are low from the next cycle on, and the counter rests at zero. After `en_i` rises, `sync_o` is high in the first cycle after the next clock edge.
- R9: A half-period input of 0 is treated as Pe = 1, which gives a 2-cycle period.
- R10: While `rst_n` is low, `hi_o`, `lo_o` and `sync_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Channel enable |
| xover_i | input | 1 | Crossover select: 1 swaps the pin waveforms |
| period_i | input | CW | Half-period in clock cycles |
| duty_i | input | CW | Duty offset from 50%, valid range 0 to period/2 |
| dead_i | input | CW | Dead time, subtracted from both pulses |
| hi_o | output | 1 | High-side pin |
| lo_o | output | 1 | Low-side pin |
| sync_o | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
The bench targets settings that push an on-time past either end of its range. One case sets a duty large enough to drive the low side negative, another a dead time that drives the high side negative. A design without saturation would wrap these values and emit a nearly full-width pulse. Odd half-periods and a half-period of 0 or 1 test the rounding that splits an odd on-time between the two halves of the counter. An off-by-one there would let the pins overlap or miscount by a cycle. Inputs are also changed at random points inside a period. A design that failed to shadow them would show a period with the wrong length or a mixed pulse width.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   typedef enum logic {
      PH_UP = 1'b0,
      PH_DN = 1'b1
   } phase_e;

   // Saturated on-time of one side over a full period (0 .. 2*pe)
   function automatic int side_on_time(int pe, int duty, int dead, bit high_side);
      int raw;
      if (high_side) raw = pe + 2 * (duty - dead);
      else           raw = pe - 2 * (duty + dead);
      if (raw < 0)      raw = 0;
      if (raw > 2 * pe) raw = 2 * pe;
      return raw;
   endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
   import cpwm_pkg::*;
#(
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [CW-1:0] per_s,
   output logic [CW-1:0] cnt_o,
   output phase_e        phase_o,
   output logic          run_o,
   output logic          load_o,
   output logic          sync_o
);

   localparam logic [CW-1:0] ONE = CW'(1);

   always_comb begin
      load_o = en && (!run_o || (phase_o == PH_DN && cnt_o == '0));
      sync_o = run_o && (phase_o == PH_UP) && (cnt_o == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o   <= '0;
         phase_o <= PH_UP;
         run_o   <= 1'b0;
      end else if (!en) begin
         cnt_o   <= '0;
         phase_o <= PH_UP;
         run_o   <= 1'b0;
      end else if (!run_o) begin
         cnt_o   <= '0;
         phase_o <= PH_UP;
         run_o   <= 1'b1;
      end else if (phase_o == PH_UP) begin
         if (cnt_o == per_s - ONE) phase_o <= PH_DN;
         else                      cnt_o   <= cnt_o + ONE;
      end else begin
         if (cnt_o == '0) phase_o <= PH_UP;
         else             cnt_o   <= cnt_o - ONE;
      end
   end

   // R1
   sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> !sync_o);

   // R1
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (cnt_o < per_s));

endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow
   import cpwm_pkg::*;
#(
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] per_in,
   input  logic [CW-1:0] duty_in,
   input  logic [CW-1:0] dead_in,
   input  logic          xov_in,
   output logic [CW-1:0] per_s,
   output logic          xov_s,
   output logic [CW:0]   hi_up_thr,
   output logic [CW:0]   hi_dn_thr,
   output logic [CW:0]   lo_up_lim,
   output logic [CW:0]   lo_dn_lim
);

   localparam int        TW  = CW + 1;
   localparam logic [CW:0] ONE_T = TW'(1);

   logic [CW-1:0] per_eff;
   logic [CW:0]   pe_t, t_hi, t_lo;
   logic [CW:0]   nx_hi_up, nx_hi_dn, nx_lo_up, nx_lo_dn;

   always_comb begin
      per_eff  = (per_in == '0) ? CW'(1) : per_in;
      pe_t     = {1'b0, per_eff};
      t_hi     = TW'(side_on_time(int'(per_eff), int'(duty_in), int'(dead_in), 1'b1));
      t_lo     = TW'(side_on_time(int'(per_eff), int'(duty_in), int'(dead_in), 1'b0));
      // odd on-times: high side takes the extra cycle on the rising half,
      // low side on the falling half, keeping the two pulses disjoint
      nx_hi_up = pe_t - ((t_hi + ONE_T) >> 1);
      nx_hi_dn = pe_t - (t_hi >> 1);
      nx_lo_up = t_lo >> 1;
      nx_lo_dn = (t_lo + ONE_T) >> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_s     <= CW'(1);
         xov_s     <= 1'b0;
         hi_up_thr <= '0;
         hi_dn_thr <= '0;
         lo_up_lim <= '0;
         lo_dn_lim <= '0;
      end else if (load) begin
         per_s     <= per_eff;
         xov_s     <= xov_in;
         hi_up_thr <= nx_hi_up;
         hi_dn_thr <= nx_hi_dn;
         lo_up_lim <= nx_lo_up;
         lo_dn_lim <= nx_lo_dn;
      end
   end

   // R7
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(per_s) && $stable(xov_s) && $stable(hi_up_thr) && $stable(lo_dn_lim)));

   // R9
   per_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_s != '0);

endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage
   import cpwm_pkg::*;
#(
   parameter int CW      = 10,
   parameter bit XOVER_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt,
   input  phase_e        phase,
   input  logic          run,
   input  logic          xov_s,
   input  logic [CW:0]   hi_up_thr,
   input  logic [CW:0]   hi_dn_thr,
   input  logic [CW:0]   lo_up_lim,
   input  logic [CW:0]   lo_dn_lim,
   output logic          hi_o,
   output logic          lo_o
);

   logic [CW:0] cnt_t;
   logic        hi_raw, lo_raw;

   always_comb begin
      cnt_t  = {1'b0, cnt};
      hi_raw = (phase == PH_UP) ? (cnt_t >= hi_up_thr) : (cnt_t >= hi_dn_thr);
      lo_raw = (phase == PH_UP) ? (cnt_t <  lo_up_lim) : (cnt_t <  lo_dn_lim);
   end

   generate
      if (XOVER_EN) begin : g_xover
         always_comb begin
            hi_o = run && (xov_s ? lo_raw : hi_raw);
            lo_o = run && (xov_s ? hi_raw : lo_raw);
         end
      end else begin : g_fixed
         logic unused_xov;
         always_comb begin
            unused_xov = xov_s;
            hi_o       = run && hi_raw;
            lo_o       = run && lo_raw;
         end
      end
   endgenerate

   // R5
   pins_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_o && lo_o));

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
   import cpwm_pkg::*;
#(
   parameter int CW       = 10,
   parameter bit XOVER_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          xover_i,
   input  logic [CW-1:0] period_i,
   input  logic [CW-1:0] duty_i,
   input  logic [CW-1:0] dead_i,
   output logic          hi_o,
   output logic          lo_o,
   output logic          sync_o
);

   generate
      if (CW < 2 || CW > 28) begin : g_bad_cw
         $error("cpwm_channel: CW must lie in 2..28");
      end
   endgenerate

   logic [CW-1:0] per_s, cnt;
   logic          xov_s, run, load;
   phase_e        phase;
   logic [CW:0]   hi_up_thr, hi_dn_thr, lo_up_lim, lo_dn_lim;

   cpwm_timebase #(.CW(CW)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_i),
      .per_s   (per_s),
      .cnt_o   (cnt),
      .phase_o (phase),
      .run_o   (run),
      .load_o  (load),
      .sync_o  (sync_o)
   );

   cpwm_shadow #(.CW(CW)) u_sh (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .per_in    (period_i),
      .duty_in   (duty_i),
      .dead_in   (dead_i),
      .xov_in    (xover_i),
      .per_s     (per_s),
      .xov_s     (xov_s),
      .hi_up_thr (hi_up_thr),
      .hi_dn_thr (hi_dn_thr),
      .lo_up_lim (lo_up_lim),
      .lo_dn_lim (lo_dn_lim)
   );

   cpwm_outstage #(.CW(CW), .XOVER_EN(XOVER_EN)) u_os (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (cnt),
      .phase     (phase),
      .run       (run),
      .xov_s     (xov_s),
      .hi_up_thr (hi_up_thr),
      .hi_dn_thr (hi_dn_thr),
      .lo_up_lim (lo_up_lim),
      .lo_dn_lim (lo_dn_lim),
      .hi_o      (hi_o),
      .lo_o      (lo_o)
   );

   // R8
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!hi_o && !lo_o && !sync_o));

   // R8
   enable_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !run) |=> sync_o);

endmodule

// File: tb/sim_cpwm_channel.sv
module sim_cpwm_channel;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_i = 1'b0;
   logic          xover_i = 1'b0;
   logic [CW-1:0] period_i = '0;
   logic [CW-1:0] duty_i = '0;
   logic [CW-1:0] dead_i = '0;
   logic          hi_o, lo_o, sync_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit started = 0;
   int len, hc, lc, e_per, e_hi, e_lo;
   string tag = "R2 R3";
   bit done = 0;
   int seed_v;

   always #2 clk = ~clk;

   cpwm_channel #(.CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .xover_i(xover_i),
      .period_i(period_i), .duty_i(duty_i), .dead_i(dead_i),
      .hi_o(hi_o), .lo_o(lo_o), .sync_o(sync_o)
   );

   function automatic int exp_on(int p, int d, int dt, bit hs);
      int pe = (p == 0) ? 1 : p;
      int v  = hs ? pe + 2 * (d - dt) : pe - 2 * (d + dt);
      if (v < 0) v = 0;
      if (v > 2 * pe) v = 2 * pe;
      return v;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic tick();
      int h, l;
      @(negedge clk);
      cyc++;
      if (hi_o && lo_o) check(0, "R5 overlap", 1, 0);
      if (sync_o) begin
         if (started) begin
            check(len == 2 * e_per, {"R1 period ", tag}, len, 2 * e_per);
            check(hc == e_hi, {"hi on-time ", tag}, hc, e_hi);
            check(lc == e_lo, {"lo on-time ", tag}, lc, e_lo);
         end
         started = 1;
         e_per = (period_i == 0) ? 1 : int'(period_i);
         h = exp_on(int'(period_i), int'(duty_i), int'(dead_i), 1'b1);
         l = exp_on(int'(period_i), int'(duty_i), int'(dead_i), 1'b0);
         e_hi = xover_i ? l : h;
         e_lo = xover_i ? h : l;
         len = 0; hc = 0; lc = 0;
      end
      if (started) begin
         len++;
         hc += int'(hi_o);
         lc += int'(lo_o);
      end
   endtask

   task automatic wait_sync();
      tick();
      while (!sync_o && cyc < 150000) tick();
   endtask

   task automatic directed(string t, int p, int d, int dt, bit x);
      period_i = CW'(p); duty_i = CW'(d); dead_i = CW'(dt); xover_i = x;
      wait_sync();
      tag = t;
      wait_sync();
      wait_sync();
   endtask

   initial begin
      seed_v = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!hi_o && !lo_o && !sync_o, "R10 reset outputs", int'({hi_o, lo_o, sync_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!hi_o && !lo_o && !sync_o, "R8 idle after reset", int'({hi_o, lo_o, sync_o}), 0);

      period_i = CW'(8);
      en_i = 1'b1;
      tick();
      check(sync_o, "R8 first sync after enable", int'(sync_o), 1);

      directed("R4 fifty", 8, 0, 0, 0);
      directed("R4 full", 8, 4, 0, 0);
      directed("R3 lo clamp", 8, 4, 2, 0);
      directed("R2 hi clamp", 8, 0, 6, 0);
      directed("R6 crossover", 10, 2, 1, 1);
      directed("R9 zero period", 0, 0, 0, 0);
      directed("R9 unit period", 1, 1, 0, 0);
      directed("R2 R3 odd", 7, 1, 0, 0);

      // R7: change inputs in the middle of a period
      tag = "R7 shadow";
      period_i = CW'(12); duty_i = CW'(3); dead_i = CW'(1); xover_i = 0;
      wait_sync();
      wait_sync();
      repeat (5) tick();
      period_i = CW'(5); duty_i = CW'(0); dead_i = CW'(0); xover_i = 1;
      wait_sync();
      wait_sync();

      // R8: disable mid-period
      repeat (3) tick();
      en_i = 1'b0;
      started = 0;
      repeat (5) begin
         tick();
         check(!hi_o && !lo_o && !sync_o, "R8 disabled outputs", int'({hi_o, lo_o, sync_o}), 0);
      end
      en_i = 1'b1;
      tick();
      check(sync_o, "R8 sync on re-enable", int'(sync_o), 1);

      // random periods with changes at random points (R1 R2 R3 R6 R7)
      tag = "R2 R3 R6 R7 random";
      wait_sync();
      for (int i = 0; i < 200; i++) begin
         int p, r;
         r = int'($urandom % (2 * e_per));
         repeat (r) tick();
         p = 1 + int'($urandom % 40);
         period_i = CW'(p);
         duty_i   = CW'($urandom % (p / 2 + 4));
         dead_i   = CW'($urandom % 5);
         xover_i  = 1'($urandom % 2);
         wait_sync();
      end
      wait_sync();

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 180000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule